// File: doc/BRIEF.md
# Byte-Lane Static RAM Model

This block is a clocked, synthesizable stand-in for a 16-bit asynchronous static RAM that has two byte lanes. It sits opposite a memory controller in simulation or FPGA emulation and answers its pin-level control signals. There are two chip selects of opposite polarity, an active-low output enable, an active-low write enable and one active-low strobe per byte. The shared bidirectional data bus is split into `din` and `dout`, plus one drive flag per lane, so a wrapper or testbench can rebuild the tri-state behaviour.

The control inputs decode into four modes: deselected, selected with outputs off, read, and write. A write wins over the output enable. A lane takes data only while its own strobe and the write window are both active. Storage is a register array. It is written on every rising edge of `clk` inside a write window, so the value held at the end of the window is the one kept. Reads are combinational by default. Setting `REG_READ` adds one register stage to the read path. Only the logical behaviour is modelled: there is no analog timing, no power state and no retention voltage. The back-pressure rules of a stream interface do not apply here, because the controller paces every access through the control pins.

Top module: `sram_lane_model`

## Requirements
- R1: When `cs1_n`=1, or `cs2`=0, or `lb_n`=`ub_n`=1, the model is deselected. `dout_oe`=2'b00 and `dout`=0, and no byte is written whatever `we_n`, `oe_n` and `din` are.
- R2: When selected with `oe_n`=1 and `we_n`=1, both lanes are undriven (`dout_oe`=2'b00, `dout`=0) and memory is unchanged.
- R3: When selected with `oe_n`=0 and `we_n`=1, `dout_oe[0]`=!`lb_n` and `dout_oe[1]`=!`ub_n`. A driven lane carries the stored byte at `addr` (lane 0 = bits 7:0, lane 1 = bits 15:8), and an undriven lane reads 8'h00.
- R4: When selected with `we_n`=0, the model writes whatever the value of `oe_n`, and `dout_oe`=2'b00.
- R5: On each rising `clk` edge inside a write, every lane whose strobe is low stores the matching byte of `din` at `addr`.
- R6: In a write, a lane whose strobe is high keeps its previous contents.
- R7: After the active-low asynchronous reset `rst_n`, every word reads 16'h0000.
- R8: The controller input `ctl_drive` (high when the controller drives the bus) must never be high in a cycle where `dout_oe` is nonzero.
- R9: When `din` changes during a multi-cycle write window, the value present at the last edge of the window is the one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for writes |
| rst_n | input | 1 | Asynchronous active-low reset; clears storage |
| addr | input | ADDR_W | Word address |
| cs1_n | input | 1 | Active-low chip select |
| cs2 | input | 1 | Active-high chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| lb_n | input | 1 | Active-low strobe, bits 7:0 |
| ub_n | input | 1 | Active-low strobe, bits 15:8 |
| din | input | 16 | Write data from the controller |
| ctl_drive | input | 1 | High when the controller drives the shared bus |
| dout | output | 16 | Read data; zero in any lane that is not driven |
| dout_oe | output | 2 | Per-lane drive flag (bit 0 = low byte) |

## Verification
On every clock, the assertions check these properties:
- the deselect, outputs-off and write cases keep both drive flags low;
- a driven lane matches the addressed storage;
- a lane written in one cycle reads back its data in the next cycle;
- a lane that was not strobed holds still;
- the controller never drives the bus while the model drives it.

Only the bench's scenarios can show the effects that span several accesses. These are:
- zero contents after reset;
- merged results of lower-only, upper-only and word writes at one address;
- writes blocked by each of the three deselect conditions;
- the last-value-wins rule of a long write window.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_NODRV = 2'd1,
    MODE_READ  = 2'd2,
    MODE_WRITE = 2'd3
  } access_mode_t;
endpackage

// File: rtl/sram_lane_decode.sv
module sram_lane_decode
  import sram_lane_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs1_n,
  input  logic             cs2,
  input  logic             oe_n,
  input  logic             we_n,
  input  logic [LANES-1:0] strobe_n,
  output access_mode_t     mode,
  output logic [LANES-1:0] lane_we,
  output logic [LANES-1:0] lane_oe
);
  logic chip_on;

  always_comb begin
    chip_on = !cs1_n && cs2 && !(&strobe_n);
    if (!chip_on)   mode = MODE_IDLE;
    else if (!we_n) mode = MODE_WRITE;
    else if (!oe_n) mode = MODE_READ;
    else            mode = MODE_NODRV;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we[g] = (mode == MODE_WRITE) && !strobe_n[g];
    assign lane_oe[g] = (mode == MODE_READ)  && !strobe_n[g];
  end

  // R1: no lane activity while any select is off
  p_desel_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs1_n || !cs2 || (&strobe_n)) |-> (lane_we == '0 && lane_oe == '0));
  // R4: write and drive never coincide
  p_wr_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(|lane_we && |lane_oe));
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
      end else if (lane_we[g]) begin
        cells[addr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = cells[addr];

    // R5: a written byte reads back at the same address next cycle
    p_lane_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(lane_we[g]) && addr == $past(addr))
        |-> rdata[g*LANE_W +: LANE_W] == $past(wdata[g*LANE_W +: LANE_W]));
    // R6: an unstrobed byte stays put while its address is held
    p_lane_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(lane_we[g]) && addr == $past(addr))
        |-> $stable(rdata[g*LANE_W +: LANE_W]));
  end
endmodule

// File: rtl/sram_lane_rdport.sv
module sram_lane_rdport
  import sram_lane_pkg::*;
#(
  parameter bit REG_READ = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] rdata,
  input  logic [LANES-1:0]  lane_oe,
  output logic [WORD_W-1:0] dout,
  output logic [LANES-1:0]  dout_oe
);
  logic [WORD_W-1:0] masked;

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign masked[g*LANE_W +: LANE_W] =
      lane_oe[g] ? rdata[g*LANE_W +: LANE_W] : '0;
  end

  if (REG_READ) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dout    <= '0;
        dout_oe <= '0;
      end else begin
        dout    <= masked;
        dout_oe <= lane_oe;
      end
    end
  end else begin : g_comb
    assign dout    = masked;
    assign dout_oe = lane_oe;
  end
endmodule

// File: rtl/sram_lane_model.sv
module sram_lane_model
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter bit REG_READ = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic [15:0]       din,
  input  logic              ctl_drive,
  output logic [15:0]       dout,
  output logic [1:0]        dout_oe
);
  access_mode_t      mode;
  logic [LANES-1:0]  lane_we, lane_oe;
  logic [WORD_W-1:0] rdata;

  sram_lane_decode u_decode (
    .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .oe_n(oe_n),
    .we_n(we_n), .strobe_n({ub_n, lb_n}), .mode(mode),
    .lane_we(lane_we), .lane_oe(lane_oe)
  );

  sram_lane_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .addr(addr), .lane_we(lane_we),
    .wdata(din), .rdata(rdata)
  );

  sram_lane_rdport #(.REG_READ(REG_READ)) u_rdport (
    .clk(clk), .rst_n(rst_n), .rdata(rdata), .lane_oe(lane_oe),
    .dout(dout), .dout_oe(dout_oe)
  );

  // R8: controller and model never drive together
  p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_drive && |dout_oe));

  if (!REG_READ) begin : g_pin_chk
    // R2: selected with both enables high leaves lanes undriven
    p_nodrv_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs1_n && cs2 && oe_n && we_n) |-> dout_oe == 2'b00);
    // R4: writing keeps outputs off whatever oe_n is
    p_wr_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs1_n && cs2 && !we_n) |-> dout_oe == 2'b00);
    // R3: a driven low lane shows storage
    p_rd_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dout_oe[0] |-> (dout[7:0] == rdata[7:0] && !lb_n));
    p_rd_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dout_oe[1] |-> (dout[15:8] == rdata[15:8] && !ub_n));
  end
endmodule

// File: tb/sram_lane_model_tb.sv
module sram_lane_model_tb;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          cs1_n = 1'b1, cs2 = 1'b0, oe_n = 1'b1, we_n = 1'b1;
  logic          lb_n = 1'b1, ub_n = 1'b1, ctl_drive = 1'b0;
  logic [15:0]   din = '0;
  logic [15:0]   dout;
  logic [1:0]    dout_oe;

  int total = 0, bad = 0;
  logic [15:0] ref_mem [1 << AW];

  always #5ns clk = ~clk;

  sram_lane_model #(.ADDR_W(AW)) u_dut (.*);

  function automatic bit sel();
    return !cs1_n && cs2 && !(lb_n && ub_n);
  endfunction

  // reference model: memory update at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < (1 << AW); i++) ref_mem[i] = 16'h0;
    end else if (sel() && !we_n) begin
      if (!lb_n) ref_mem[addr][7:0]  = din[7:0];
      if (!ub_n) ref_mem[addr][15:8] = din[15:8];
    end
  end

  // per-cycle comparison of the pins against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      logic [1:0]  e_oe;
      logic [15:0] e_d;
      string       tag;
      e_oe = 2'b00;
      if (!sel())      tag = "R1";
      else if (!we_n)  tag = "R4";
      else if (oe_n)   tag = "R2";
      else begin
        tag  = "R3";
        e_oe = {!ub_n, !lb_n};
      end
      e_d = {e_oe[1] ? ref_mem[addr][15:8] : 8'h00,
             e_oe[0] ? ref_mem[addr][7:0]  : 8'h00};
      total++;
      if (dout_oe !== e_oe || dout !== e_d) begin
        bad++;
        $display("FAIL %s: oe=%b dout=%h expected oe=%b dout=%h",
                 tag, dout_oe, dout, e_oe, e_d);
      end
      total++;
      if (ctl_drive && dout_oe !== 2'b00) begin
        bad++;
        $display("FAIL R8: dout_oe=%b expected 00 while controller drives", dout_oe);
      end
    end
  end

  task automatic drive(input logic [AW-1:0] a, input logic c1, input logic c2,
                       input logic o, input logic w, input logic l,
                       input logic u, input logic [15:0] d);
    @(posedge clk); #1;
    addr = a; cs1_n = c1; cs2 = c2; oe_n = o; we_n = w;
    lb_n = l; ub_n = u; din = d; ctl_drive = !w;
  endtask

  task automatic expect_word(input logic [AW-1:0] a, input logic [15:0] exp,
                             input string tag);
    drive(a, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
    @(negedge clk); #1;
    total++;
    if (dout !== exp) begin
      bad++;
      $display("FAIL %s: addr=%0d got %h expected %h", tag, a, dout, exp);
    end
  endtask

  initial begin
    #2ms;
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R7: cleared after reset
    expect_word(10'd0, 16'h0000, "R7");
    expect_word(10'd1023, 16'h0000, "R7");
    // R5: word write
    drive(10'd5, 0, 1, 1, 0, 0, 0, 16'hA1B2);
    expect_word(10'd5, 16'hA1B2, "R5");
    // R6: lower-only then upper-only, the other byte kept
    drive(10'd5, 0, 1, 1, 0, 0, 1, 16'h77CC);
    expect_word(10'd5, 16'hA1CC, "R6");
    drive(10'd5, 0, 1, 1, 0, 1, 0, 16'hDD33);
    expect_word(10'd5, 16'hDDCC, "R6");
    // R4: write with oe_n low
    drive(10'd7, 0, 1, 0, 0, 0, 0, 16'h1234);
    expect_word(10'd7, 16'h1234, "R4");
    // R9: multi-cycle window, last value wins
    drive(10'd9, 0, 1, 1, 0, 0, 0, 16'h1111);
    drive(10'd9, 0, 1, 1, 0, 0, 0, 16'h2222);
    drive(10'd9, 0, 1, 1, 0, 0, 0, 16'h3333);
    expect_word(10'd9, 16'h3333, "R9");
    // R1: each deselect condition blocks a write
    drive(10'd5, 1, 1, 1, 0, 0, 0, 16'hFFFF);
    drive(10'd5, 0, 0, 1, 0, 0, 0, 16'hEEEE);
    drive(10'd5, 0, 1, 1, 0, 1, 1, 16'hDDDD);
    expect_word(10'd5, 16'hDDCC, "R1");
    // R3: byte-only reads and R2: outputs off
    drive(10'd5, 0, 1, 0, 1, 0, 1, 16'h0);
    drive(10'd5, 0, 1, 0, 1, 1, 0, 16'h0);
    drive(10'd5, 0, 1, 1, 1, 0, 0, 16'h0);
    // mixed random traffic over a small address range
    for (int n = 0; n < 400; n++) begin
      logic [3:0] ctl;
      ctl = 4'($urandom);
      drive(AW'($urandom_range(0, 15)), ($urandom_range(0, 7) == 0),
            ($urandom_range(0, 7) != 0), ctl[0], ctl[1], ctl[2], ctl[3],
            16'($urandom));
    end
    drive(10'd0, 1, 0, 1, 1, 1, 1, 16'h0);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule